// File: doc/BRIEF.md
# Sparse-Tree Carry-Select Adder

A purely combinational 64-bit binary adder that divides the carry work into two parallel paths. A sparse parallel-prefix network works on 4-bit groups. It reduces each group's per-bit generate and propagate terms with two-input merges. It then forms only the carry that enters each group, together with the final carry-out, in logarithmic depth, with no ripple between groups.

Beside the prefix network, each 4-bit group holds a small conditional-sum unit. This unit computes the group's sum twice, once assuming a carry-in of 0 and once assuming 1. The group carry from the sparse network then picks the right candidate through a multiplexer.

The block holds no state and needs no clock. A pipeline stage, if the surrounding datapath wants one, is placed outside the adder.

Top module: `sat_adder`

## Requirements
- R1: `sum_o` equals the low 64 bits of `a_i + b_i + cin_i` for every input combination.
- R2: `cout_o` equals bit 64 of the 65-bit result of `a_i + b_i + cin_i`.
- R3: With `b_i` zero, `sum_o` equals `a_i` when `cin_i` is 0 and equals `a_i + 1` when `cin_i` is 1.
- R4: A carry made in the low bits reaches every 4-bit group boundary: adding 1 to 2^(4k)-1 yields 2^(4k) for k = 1..15, and for k = 16 yields zero sum with `cout_o` 1.
- R5: A group whose four bits all propagate (a_i XOR b_i all ones) passes its incoming carry unchanged to the next group. Operands with `b_i == ~a_i` therefore give an all-ones sum when `cin_i` is 0, and a zero sum with `cout_o` 1 when `cin_i` is 1.
- R6: Zero operands with `cin_i` 0 give a zero sum and `cout_o` 0.
- R7: The outputs depend only on the present inputs. Reapplying an earlier input after a different one gives the same result as before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 64 | Sum, low 64 bits |
| cout_o | output | 1 | Carry out of bit 63 |

## Verification
Suppose a group carry from the sparse network is wrong. The whole affected 4-bit nibble of `sum_o` then shows the other candidate, which is off by exactly one in that nibble, or `cout_o` flips. A wrong internal carry inside a conditional-sum unit corrupts the nibble above the faulty bit, but only for the one assumed carry-in that the failing case selects. Since nothing is registered, any such fault is visible at the ports in the same cycle the operands are applied. Long all-propagate chains, boundary-crossing increments and alternating patterns are the inputs that expose each of these carry sources.

// File: rtl/sat_pkg.sv
`timescale 1ns/1ps
package sat_pkg;
  localparam int unsigned DEF_WIDTH = 64;
  localparam int unsigned DEF_GROUP = 4;
endpackage

// File: rtl/sat_grp_pg.sv
`timescale 1ns/1ps
// Group generate/propagate from per-bit terms via a radix-2 merge tree.
module sat_grp_pg #(
  parameter int unsigned GROUP = sat_pkg::DEF_GROUP
) (
  input  logic [GROUP-1:0] g_i,
  input  logic [GROUP-1:0] p_i,
  output logic             grp_g_o,
  output logic             grp_p_o
);
  logic [GROUP-1:0] tg, tp;

  always_comb begin
    tg = g_i;
    tp = p_i;
    for (int s = 1; s < int'(GROUP); s = s * 2) begin
      for (int i = 0; i + 2 * s - 1 < int'(GROUP); i = i + 2 * s) begin
        tg[i+2*s-1] = tg[i+2*s-1] | (tp[i+2*s-1] & tg[i+s-1]);
        tp[i+2*s-1] = tp[i+2*s-1] & tp[i+s-1];
      end
    end
    grp_g_o = tg[GROUP-1];
    grp_p_o = tp[GROUP-1];
  end
endmodule

// File: rtl/sat_sparse_tree.sv
`timescale 1ns/1ps
// Parallel prefix over group terms; element 0 carries the external carry-in.
module sat_sparse_tree #(
  parameter int unsigned NGRP = sat_pkg::DEF_WIDTH / sat_pkg::DEF_GROUP
) (
  input  logic [NGRP-1:0] grp_g_i,
  input  logic [NGRP-1:0] grp_p_i,
  input  logic            cin_i,
  output logic [NGRP-1:0] grp_c_o,
  output logic            cout_o
);
  localparam int unsigned NE  = NGRP + 1;
  localparam int unsigned LVL = $clog2(NE);

  logic [NE-1:0] tg, tp;

  always_comb begin
    tg = {grp_g_i, cin_i};
    tp = {grp_p_i, 1'b0};
    for (int l = 0; l < int'(LVL); l++) begin
      // descending so lower entries still hold the previous level
      for (int i = int'(NE) - 1; i >= (1 << l); i--) begin
        tg[i] = tg[i] | (tp[i] & tg[i-(1<<l)]);
        tp[i] = tp[i] & tp[i-(1<<l)];
      end
    end
    grp_c_o = tg[NGRP-1:0];
    cout_o  = tg[NGRP];
  end

  logic [NE-1:0] c_all;
  assign c_all = {cout_o, grp_c_o};

  always_comb begin
    for (int j = 0; j < int'(NGRP); j++) begin
      // R5
      pass_chk: assert (!grp_p_i[j] || (c_all[j+1] == c_all[j]))
        else $error("group %0d did not pass its carry", j);
      // R4
      gen_carry_chk: assert (!grp_g_i[j] || c_all[j+1])
        else $error("group %0d generate lost", j);
    end
  end
endmodule

// File: rtl/sat_csum.sv
`timescale 1ns/1ps
// Conditional-sum unit: both candidate sums, selected by the group carry.
module sat_csum #(
  parameter int unsigned GROUP = sat_pkg::DEF_GROUP
) (
  input  logic [GROUP-1:0] g_i,
  input  logic [GROUP-1:0] p_i,
  input  logic             sel_i,
  output logic [GROUP-1:0] sum_o
);
  logic [GROUP:0]   c0, c1;
  logic [GROUP-1:0] s0, s1;

  assign c0[0] = 1'b0;
  assign c1[0] = 1'b1;

  for (genvar k = 0; k < GROUP; k++) begin : g_bit
    assign c0[k+1] = g_i[k] | (p_i[k] & c0[k]);
    assign c1[k+1] = g_i[k] | (p_i[k] & c1[k]);
    assign s0[k]   = p_i[k] ^ c0[k];
    assign s1[k]   = p_i[k] ^ c1[k];
  end

  assign sum_o = sel_i ? s1 : s0;

  always_comb begin
    // R5
    cand_step_chk: assert ({c1[GROUP], s1} == {c0[GROUP], s0} + (GROUP+1)'(1))
      else $error("candidates not one apart");
    // R5
    cand_order_chk: assert (!c0[GROUP] || c1[GROUP])
      else $error("carry-1 candidate below carry-0 candidate");
  end
endmodule

// File: rtl/sat_adder.sv
`timescale 1ns/1ps
module sat_adder #(
  parameter int unsigned WIDTH = sat_pkg::DEF_WIDTH,
  parameter int unsigned GROUP = sat_pkg::DEF_GROUP
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int unsigned NGRP = WIDTH / GROUP;

  logic [WIDTH-1:0] bit_g, bit_p;
  logic [NGRP-1:0]  grp_g, grp_p, grp_c;

  assign bit_g = a_i & b_i;
  assign bit_p = a_i ^ b_i;

  for (genvar j = 0; j < NGRP; j++) begin : g_grp
    sat_grp_pg #(.GROUP(GROUP)) u_pg (
      .g_i    (bit_g[j*GROUP +: GROUP]),
      .p_i    (bit_p[j*GROUP +: GROUP]),
      .grp_g_o(grp_g[j]),
      .grp_p_o(grp_p[j])
    );
    sat_csum #(.GROUP(GROUP)) u_cs (
      .g_i  (bit_g[j*GROUP +: GROUP]),
      .p_i  (bit_p[j*GROUP +: GROUP]),
      .sel_i(grp_c[j]),
      .sum_o(sum_o[j*GROUP +: GROUP])
    );
  end

  sat_sparse_tree #(.NGRP(NGRP)) u_tree (
    .grp_g_i(grp_g),
    .grp_p_i(grp_p),
    .cin_i  (cin_i),
    .grp_c_o(grp_c),
    .cout_o (cout_o)
  );

  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(cin_i);

  always_comb begin
    // R1
    sum_ref_chk: assert (sum_o == ref_sum[WIDTH-1:0]) else $error("sum mismatch");
    // R2
    cout_ref_chk: assert (cout_o == ref_sum[WIDTH]) else $error("carry-out mismatch");
    // R3
    ident_chk: assert ((b_i != '0) || cin_i || (sum_o == a_i && !cout_o))
      else $error("identity add failed");
    // R6
    zero_chk: assert ((a_i != '0) || (b_i != '0) || cin_i || ({cout_o, sum_o} == '0))
      else $error("zero add failed");
  end
endmodule

// File: tb/sat_adder_test.sv
`timescale 1ns/1ps
module sat_adder_test;
  logic        clk = 1'b0;
  logic [63:0] a, b, sum;
  logic        cin, cout;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sat_adder uut (.a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout));

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic        cin;
    logic [63:0] s;
    logic        co;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{64'h0, 64'h0, 1'b0, 64'h0, 1'b0},                                          // R6
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 64'h0, 1'b1},                        // R3
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 64'h0, 1'b1},                        // R4
    '{64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0}, // R5
    '{64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1, 64'h0, 1'b1},      // R5
    '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 64'h0, 1'b1},      // R2
    '{64'hF, 64'h1, 1'b0, 64'h10, 1'b0},                                         // R4
    '{64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 64'h8000_0000_0000_0000, 1'b0},      // R4
    '{64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b0, 64'h2222_2222_2222_2211, 1'b0}, // R1
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1}  // R2
  };

  task automatic apply(input logic [63:0] ta, input logic [63:0] tb_, input logic tc);
    @(negedge clk);
    a = ta; b = tb_; cin = tc;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [63:0] es, input logic ec);
    checks++;
    if (sum !== es || cout !== ec) begin
      failures++;
      $display("FAIL %s: sum=%h cout=%b expected sum=%h cout=%b", req, sum, cout, es, ec);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [64:0] r;
    logic [63:0] ra, rb, hold_s;
    logic        rc, hold_c;
    a = '0; b = '0; cin = 1'b0;

    // R6: idle state with zero inputs
    apply('0, '0, 1'b0);
    chk("R6 zero start", 64'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].cin);
      chk($sformatf("R1 R2 table[%0d]", i), VECS[i].s, VECS[i].co);
    end

    // R4: carry reaches every group boundary
    for (int k = 1; k <= 16; k++) begin
      logic [64:0] m;
      m = (65'd1 << (4 * k)) - 65'd1;
      apply(m[63:0], 64'h1, 1'b0);
      m = m + 65'd1;
      chk($sformatf("R4 boundary k=%0d", k), m[63:0], m[64]);
    end

    // R3: carry-in alone increments, zero carry-in is identity
    for (int i = 0; i < 50; i++) begin
      ra = {$urandom, $urandom};
      apply(ra, '0, 1'b0);
      chk("R3 identity", ra, 1'b0);
      apply(ra, '0, 1'b1);
      r = {1'b0, ra} + 65'd1;
      chk("R3 increment", r[63:0], r[64]);
    end

    // R5: all-propagate operands
    for (int i = 0; i < 50; i++) begin
      ra = {$urandom, $urandom};
      rc = 1'($urandom);
      apply(ra, ~ra, rc);
      chk("R5 all propagate", rc ? 64'h0 : 64'hFFFF_FFFF_FFFF_FFFF, rc);
    end

    // R1 R2: random operands
    for (int i = 0; i < 3000; i++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      rc = 1'($urandom);
      apply(ra, rb, rc);
      r = {1'b0, ra} + {1'b0, rb} + 65'(rc);
      chk("R1 R2 random", r[63:0], r[64]);
    end

    // R7: same inputs after different history
    ra = 64'h0123_4567_89AB_CDEF;
    rb = 64'hFEDC_BA98_7654_3210;
    apply(ra, rb, 1'b1);
    hold_s = sum; hold_c = cout;
    chk("R7 first", 64'h0, 1'b1);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    apply(ra, rb, 1'b1);
    chk("R7 repeat", hold_s, hold_c);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule